// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is an I2C target that only accepts register writes into a byte-wide register file that sits outside it. A strap input chooses one of two 7-bit bus addresses. After a START, the target takes in an address byte. If the address matches and the direction bit asks for a write, the target acknowledges the byte.

The first byte after the address is loaded into an internal register pointer. Each byte after that goes out on a write port as an address, a data byte and a one-cycle strobe, and the pointer then steps forward by one. A transfer may start at any register and may carry any number of bytes. It ends at STOP.

The SCL and SDA inputs are asynchronous to the system clock. Each passes through a synchronizer chain, and all bus events are decoded in the system clock domain. The only bus output is the SDA pull-down used for acknowledges. Read transfers, clock stretching and 10-bit addressing are not supported.

Top module: `i2c_regwr_slave`

## Requirements
- R1: The target answers to 7-bit address 0x20 when `addr_sel_i` is 0 and 0x21 when it is 1 (8-bit forms 0x40 and 0x42). Bytes are received MSB first.
- R2: An address byte whose last bit is 1 (a read) is not acknowledged, and no write strobe follows until the next START.
- R3: `sda_pull_o` goes high while SCL is low before the ninth clock of each accepted byte, stays high through that clock's high phase, and drops after SCL falls again.
- R4: The first byte after an accepted address loads the register pointer, is acknowledged, and produces no write strobe.
- R5: Each later byte gives exactly one single-cycle `wr_en_o` pulse, with `wr_data_o` equal to the byte and `wr_addr_o` equal to the current pointer.
- R6: The pointer rises by one after every data byte and wraps from 0xFF to 0x00.
- R7: A STOP (SDA rising while SCL is high) returns the target to idle. SCL activity after it, with no START, causes no acknowledge and no write.
- R8: A repeated START (SDA falling while SCL is high) during a transfer restarts address-byte reception.
- R9: During and after reset, `sda_pull_o` and `wr_en_o` are low.
- R10: A non-matching address is not acknowledged. The target then ignores all bytes until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| addr_sel_i | input | 1 | Strap that selects the bus address |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 8 | Data byte of the current write |
| wr_en_o | output | 1 | One-cycle write strobe |

## Verification
A wrong receive state shows up first on the acknowledge pin. A bit counter or byte-phase error moves or drops the pull-down in the ninth clock of the very byte where the fault occurs. A pointer error appears on `wr_addr_o` at the next write strobe, no more than about four system clocks after the eighth SCL falling edge of the data byte. Wrap-around and repeated-START cases are aimed at the points where a pointer or phase fault would stay hidden in ordinary streams.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_DAT,
      ST_DAT_ACK
   } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic prev_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign prev_o  = prev_q;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
   input  logic scl_now,
   input  logic scl_prev,
   input  logic sda_now,
   input  logic sda_prev,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_held_high;

   always_comb begin
      scl_held_high = scl_now & scl_prev;
      scl_rise      = scl_now & ~scl_prev;
      scl_fall      = ~scl_now & scl_prev;
      start_det     = scl_held_high & sda_prev & ~sda_now;
      stop_det      = scl_held_high & ~sda_prev & sda_now;
   end
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
   import i2c_wr_pkg::*;
#(
   parameter logic [6:0] ADDR_SEL0 = 7'h20,
   parameter logic [6:0] ADDR_SEL1 = 7'h21,
   parameter bit         STRAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              addr_sel,
   output logic              sda_pull,
   output logic [BYTE_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_en
);
   localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

   rx_state_t            state_q;
   logic [BIT_CNT_W-1:0] bit_cnt_q;
   logic [BYTE_W-1:0]    shift_q;
   logic [BYTE_W-1:0]    ptr_q;
   logic [6:0]           dev_addr;
   logic                 byte_done;
   logic                 rx_phase;

   generate
      if (STRAP_EN) begin : g_strap
         assign dev_addr = addr_sel ? ADDR_SEL1 : ADDR_SEL0;
      end else begin : g_fixed
         logic unused_sel;
         assign unused_sel = addr_sel;
         assign dev_addr   = ADDR_SEL0;
      end
   endgenerate

   assign rx_phase  = (state_q == ST_DEV) || (state_q == ST_PTR) || (state_q == ST_DAT);
   assign byte_done = rx_phase && scl_fall && (bit_cnt_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         shift_q   <= '0;
         ptr_q     <= '0;
         sda_pull  <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_en     <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state_q  <= ST_IDLE;
            sda_pull <= 1'b0;
         end else if (start_det) begin
            state_q   <= ST_DEV;
            bit_cnt_q <= '0;
            sda_pull  <= 1'b0;
         end else if (rx_phase && scl_rise && (bit_cnt_q < LAST_BIT)) begin
            shift_q   <= {shift_q[BYTE_W-2:0], sda_lvl};
            bit_cnt_q <= bit_cnt_q + 1'b1;
         end else if (byte_done) begin
            unique case (state_q)
               ST_DEV: begin
                  if ((shift_q[7:1] == dev_addr) && !shift_q[0]) begin
                     state_q  <= ST_DEV_ACK;
                     sda_pull <= 1'b1;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
               ST_PTR: begin
                  ptr_q    <= shift_q;
                  state_q  <= ST_PTR_ACK;
                  sda_pull <= 1'b1;
               end
               default: begin
                  wr_addr  <= ptr_q;
                  wr_data  <= shift_q;
                  wr_en    <= 1'b1;
                  ptr_q    <= ptr_q + 1'b1;
                  state_q  <= ST_DAT_ACK;
                  sda_pull <= 1'b1;
               end
            endcase
         end else if (scl_fall) begin
            unique case (state_q)
               ST_DEV_ACK: begin
                  state_q <= ST_PTR; bit_cnt_q <= '0; sda_pull <= 1'b0;
               end
               ST_PTR_ACK, ST_DAT_ACK: begin
                  state_q <= ST_DAT; bit_cnt_q <= '0; sda_pull <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   // R5: a write strobe lasts one cycle
   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   // R6: the pointer has moved one past the register just written
   p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (ptr_q == wr_addr + 8'd1));
   // R2 / R10: the idle target never drives the bus
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sda_pull);
   // R7: STOP always leads to idle
   p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state_q == ST_IDLE));
   // R8: START always restarts address reception
   p_start_dev_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state_q == ST_DEV) && (bit_cnt_q == '0));
   // R3: the pull-down begins only while SCL is low
   p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_lvl);
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
   import i2c_wr_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_SEL0   = 7'h20,
   parameter logic [6:0] ADDR_SEL1   = 7'h21,
   parameter bit         STRAP_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       addr_sel_i,
   output logic       sda_pull_o,
   output logic [7:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   output logic       wr_en_o
);
   localparam int N_LINES = 2;

   generate
      if (ADDR_SEL0 == ADDR_SEL1 && STRAP_EN) begin : g_bad_addr
         $error("i2c_regwr_slave: strap addresses must differ");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] lvl;
   logic [N_LINES-1:0] prv;
   logic scl_rise, scl_fall, start_det, stop_det;

   assign raw_lines = {sda_i, scl_i};

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_sync
         i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[i]),
            .level_o(lvl[i]),
            .prev_o (prv[i])
         );
      end
   endgenerate

   i2c_cond_detect u_cond (
      .scl_now  (lvl[0]),
      .scl_prev (prv[0]),
      .sda_now  (lvl[1]),
      .sda_prev (prv[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_wr_fsm #(
      .ADDR_SEL0(ADDR_SEL0),
      .ADDR_SEL1(ADDR_SEL1),
      .STRAP_EN (STRAP_EN)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (lvl[0]),
      .sda_lvl  (lvl[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .addr_sel (addr_sel_i),
      .sda_pull (sda_pull_o),
      .wr_addr  (wr_addr_o),
      .wr_data  (wr_data_o),
      .wr_en    (wr_en_o)
   );

   // R9: no bus drive or write right after reset
   p_reset_quiet_r9: assert property (@(posedge clk)
      $rose(rst_n) |-> !sda_pull_o && !wr_en_o);
endmodule

// File: tb/i2c_regwr_slave_tb.sv
module i2c_regwr_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sel = 1'b0;
   logic sda_pull_o, wr_en_o;
   logic [7:0] wr_addr_o, wr_data_o;
   logic sda_bus;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0] cap_a [0:255];
   logic [7:0] cap_d [0:255];
   int cap_n = 0;
   logic [7:0] txd [0:7];

   assign sda_bus = sda_m & ~sda_pull_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_regwr_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .addr_sel_i(sel), .sda_pull_o(sda_pull_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .wr_en_o(wr_en_o));

   always @(negedge clk) begin
      if (wr_en_o && cap_n < 256) begin
         cap_a[cap_n] = wr_addr_o;
         cap_d[cap_n] = wr_data_o;
         cap_n++;
      end
   end

   function automatic bit addr_ok(input logic [6:0] a, input logic rw, input logic s);
      return !rw && (a == (s ? 7'h21 : 7'h20));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; waitn(H);
      scl_m = 1'b1; waitn(H);
      sda_m = 1'b0; waitn(H);
      scl_m = 1'b0; waitn(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; waitn(H);
      scl_m = 1'b1; waitn(H);
      sda_m = 1'b1; waitn(2*H);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      logic ack;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; waitn(H);
         scl_m = 1'b1; waitn(H);
         scl_m = 1'b0;
      end
      sda_m = 1'b1; waitn(H);
      scl_m = 1'b1; waitn(H/2);
      ack = sda_pull_o;
      waitn(H/2);
      scl_m = 1'b0;
      chk(ack == exp_ack, req, int'(ack), int'(exp_ack));
      waitn(H);
      chk(sda_pull_o == 1'b0, "R3 release", int'(sda_pull_o), 0);
   endtask

   // Full transfer: address, pointer, nb data bytes from txd, then STOP
   task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] ptr,
                       input int nb, input string req);
      int base;
      bit m;
      base = cap_n;
      m = addr_ok(a, rw, sel);
      bus_start();
      send_byte({a, rw}, m, req);
      send_byte(ptr, m, m ? "R4 pointer ack" : "R10 ignored byte");
      for (int i = 0; i < nb; i++)
         send_byte(txd[i], m, m ? "R3 data ack" : "R10 ignored byte");
      bus_stop();
      chk(cap_n - base == (m ? nb : 0), "R5 write count", cap_n - base, m ? nb : 0);
      if (m && cap_n - base == nb) begin
         for (int i = 0; i < nb; i++) begin
            chk(cap_a[base+i] == 8'(ptr + 8'(i)), "R6 write address",
                int'(cap_a[base+i]), int'(8'(ptr + 8'(i))));
            chk(cap_d[base+i] == txd[i], "R5 write data",
                int'(cap_d[base+i]), int'(txd[i]));
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      void'($urandom(32'h5eed_1234));
      waitn(5);
      chk(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R9 reset", int'(sda_pull_o), 0);
      rst_n = 1'b1;
      waitn(5);
      chk(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R9 after reset", int'(sda_pull_o), 0);

      // R1 / R5: select 0, address 0x20, three bytes
      sel = 1'b0;
      txd[0] = 8'hA5; txd[1] = 8'h3C; txd[2] = 8'h81;
      xfer(7'h20, 1'b0, 8'h10, 3, "R1 addr 0x20 ack");
      // R1: select 1 moves the address to 0x21
      sel = 1'b1;
      xfer(7'h20, 1'b0, 8'h10, 2, "R10 old address nack");
      txd[0] = 8'h11;
      xfer(7'h21, 1'b0, 8'h40, 1, "R1 addr 0x21 ack");
      // R2: read request
      xfer(7'h21, 1'b1, 8'h00, 2, "R2 read nack");
      sel = 1'b0;
      // R4: pointer only, no write
      xfer(7'h20, 1'b0, 8'h77, 0, "R4 pointer only");
      // R6: wrap
      txd[0] = 8'hDE; txd[1] = 8'hAD; txd[2] = 8'hBE;
      xfer(7'h20, 1'b0, 8'hFE, 3, "R6 wrap addr ack");

      // R8: repeated START
      base = cap_n;
      bus_start();
      send_byte({7'h20, 1'b0}, 1'b1, "R8 first addr");
      send_byte(8'h05, 1'b1, "R8 first ptr");
      send_byte(8'h5A, 1'b1, "R8 first data");
      sda_m = 1'b1; waitn(H);
      scl_m = 1'b1; waitn(H);
      sda_m = 1'b0; waitn(H);
      scl_m = 1'b0; waitn(H);
      send_byte({7'h20, 1'b0}, 1'b1, "R8 addr after restart");
      send_byte(8'h09, 1'b1, "R8 ptr after restart");
      send_byte(8'hC3, 1'b1, "R8 data after restart");
      bus_stop();
      chk(cap_n - base == 2, "R8 write count", cap_n - base, 2);
      if (cap_n - base == 2) begin
         chk(cap_a[base] == 8'h05 && cap_d[base] == 8'h5A, "R8 first write",
             int'(cap_a[base]), 8'h05);
         chk(cap_a[base+1] == 8'h09 && cap_d[base+1] == 8'hC3, "R8 second write",
             int'(cap_a[base+1]), 8'h09);
      end

      // R7: clocks after STOP without START
      base = cap_n;
      begin
         bit seen;
         seen = 1'b0;
         scl_m = 1'b0; waitn(H);
         for (int i = 0; i < 27; i++) begin
            sda_m = (i % 3) == 0; waitn(H);
            scl_m = 1'b1; waitn(H/2);
            if (sda_pull_o) seen = 1'b1;
            waitn(H/2);
            scl_m = 1'b0;
         end
         sda_m = 1'b1; waitn(H);
         scl_m = 1'b1; waitn(2*H);
         chk(!seen, "R7 no ack when idle", int'(seen), 0);
         chk(cap_n == base, "R7 no write when idle", cap_n - base, 0);
      end

      // Random transfers
      for (int t = 0; t < 40; t++) begin
         logic [6:0] a;
         logic rw;
         int kind;
         int nb;
         logic [7:0] p;
         sel  = 1'($urandom_range(0, 1));
         kind = $urandom_range(0, 5);
         rw   = (kind == 4);
         a    = (kind == 5) ? 7'($urandom_range(0, 127)) : (sel ? 7'h21 : 7'h20);
         nb   = $urandom_range(0, 4);
         p    = 8'($urandom_range(0, 255));
         for (int i = 0; i < 8; i++) txd[i] = 8'($urandom_range(0, 255));
         xfer(a, rw, p, nb, addr_ok(a, rw, sel) ? "R1 random ack" : "R10 random nack");
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule